// File: doc/BRIEF.md
# Store Buffer Eviction Entry Controller

This block tracks every entry of a store buffer while its line is written back to the data cache through the cache's shared main pipeline. Each entry is in one of six states: free, held (holding store data, not yet evicting), sending (waiting for a slot at stage S0), pipelined (between S0 and S2), replay-queued, and issued (cache request sent, waiting for the response). The cache request is sent only when the entry reaches S2. If S2 cannot send it, the entry leaves the pipeline and joins an ordered replay queue. That queue asks for S0 again ahead of fresh evictions.

New stores are also resolved here. A store merges into a held entry for the same line. Otherwise it takes the lowest free entry. If its line is already being evicted, the new entry is marked as a linked secondary: it may not start its own eviction until the earlier eviction of that line is released. Data storage and the cache itself sit outside the block.

Top module: `sb_evict_ctrl`

## Requirements
- R1: After reset all entries are free. `busy_o` is zero, and `pipe_req_o`, `cache_req_o` and `rel_o` are low.
- R2: A valid store decision is shown on `st_act_o` in the same cycle, with this encoding: 0 = no action (buffer full or no store), 1 = merge into the held entry `st_idx_o` with the same line, 2 = allocate the lowest-index free entry `st_idx_o`.
- R3: If the store's line matches an entry whose eviction is in progress (sending, pipelined, replay-queued or issued), the store never merges into that entry. If no held entry matches, it gets code 3: allocate the lowest free entry as a linked secondary.
- R4: An eviction request is accepted only for a held entry without a link. That entry is counted in `busy_o` from the next cycle. A request for any other entry has no effect.
- R5: Sending entries ask for S0 in lowest-index order. A grant moves the entry into the pipeline without raising `cache_req_o`.
- R6: A successful S2 result for a pipelined entry raises `cache_req_o` in the same cycle, with that entry's index and line. The entry stays busy.
- R7: A failed S2 result moves the entry into the replay queue. Replay entries ask for S0 ahead of any fresh eviction, in the order in which they failed.
- R8: `rel_o` pulses in the same cycle as a response for an issued entry, and that entry is free from the next cycle. A response for an entry that is not issued is ignored.
- R9: A release clears the link of every entry with the same line, so a former secondary entry can then be evicted.
- R10: A sending entry that is not granted keeps its request and its index, and does not enter the replay queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | A new store is presented |
| st_line_i | input | LINE_W | Line address of the new store |
| st_act_o | output | 2 | Store decision code (R2/R3) |
| st_idx_o | output | IDX_W | Entry chosen for the store |
| evict_req_i | input | 1 | Request to evict an entry |
| evict_idx_i | input | IDX_W | Entry to evict |
| pipe_req_o | output | 1 | Request for main pipeline S0 |
| pipe_idx_o | output | IDX_W | Entry that is asking for S0 |
| pipe_line_o | output | LINE_W | Line of the requesting entry |
| pipe_gnt_i | input | 1 | S0 admission grant for the current request |
| s2_valid_i | input | 1 | An S2 result is present |
| s2_idx_i | input | IDX_W | Entry the S2 result belongs to |
| s2_ok_i | input | 1 | 1 = S2 issued the request, 0 = S2 failed |
| cache_req_o | output | 1 | Cache write request sent at S2 |
| cache_idx_o | output | IDX_W | Entry of the cache request |
| cache_line_o | output | LINE_W | Line of the cache request |
| resp_valid_i | input | 1 | A cache response is present |
| resp_idx_i | input | IDX_W | Entry the response belongs to |
| rel_o | output | 1 | Entry released |
| rel_idx_o | output | IDX_W | Released entry |
| busy_o | output | NUM_ENT | Per-entry flag: eviction in progress |

## Verification
Some rules are checked by the assertions on every cycle. A merge never targets a busy entry, and a secondary allocation never lands on one. Every S0 request and every cache request comes from a busy entry. An entry only becomes busy after an eviction request for it, and only stops being busy after its own release. Other behaviour can only be shown by the bench's scenarios: lowest-index and replay-first ordering of S0 requests, failure-order replay, links being cleared by a release, and merge versus allocate choices against a reference model under random store traffic.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [2:0] {
    E_FREE, E_HELD, E_SEND, E_PIPE, E_RPLQ, E_ISSUED
  } ent_state_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0, ACT_MERGE = 2'd1, ACT_ALLOC = 2'd2, ACT_SEC = 2'd3
  } st_act_e;
endpackage

// File: rtl/sbe_pick.sv
module sbe_pick #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  in_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |in_i;
endmodule

// File: rtl/sbe_replay_fifo.sv
module sbe_replay_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/sbe_entry.sv
module sbe_entry
  import sbe_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              alloc_link_i,
  input  logic              evict_i,
  input  logic              grant_i,
  input  logic              s2_ok_i,
  input  logic              s2_fail_i,
  input  logic              resp_i,
  input  logic              link_clr_i,
  output ent_state_e        state_o,
  output logic [LINE_W-1:0] line_o,
  output logic              link_o
);
  ent_state_e        st_q;
  logic [LINE_W-1:0] line_q;
  logic              link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_FREE;
      line_q <= '0;
      link_q <= 1'b0;
    end else begin
      unique case (st_q)
        E_FREE: if (alloc_i) begin
          st_q   <= E_HELD;
          line_q <= alloc_line_i;
        end
        E_HELD:         if (evict_i && !link_q) st_q <= E_SEND;
        E_SEND, E_RPLQ: if (grant_i) st_q <= E_PIPE;
        E_PIPE: begin
          if (s2_ok_i)        st_q <= E_ISSUED;
          else if (s2_fail_i) st_q <= E_RPLQ;
        end
        E_ISSUED:       if (resp_i) st_q <= E_FREE;
        default:        st_q <= E_FREE;
      endcase
      if (st_q == E_FREE && alloc_i) link_q <= alloc_link_i;
      else if (link_clr_i)           link_q <= 1'b0;
    end
  end

  assign state_o = st_q;
  assign line_o  = line_q;
  assign link_o  = link_q;
endmodule

// File: rtl/sb_evict_ctrl.sv
module sb_evict_ctrl
  import sbe_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int LINE_W  = 26,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               st_valid_i,
  input  logic [LINE_W-1:0]  st_line_i,
  output logic [1:0]         st_act_o,
  output logic [IDX_W-1:0]   st_idx_o,
  input  logic               evict_req_i,
  input  logic [IDX_W-1:0]   evict_idx_i,
  output logic               pipe_req_o,
  output logic [IDX_W-1:0]   pipe_idx_o,
  output logic [LINE_W-1:0]  pipe_line_o,
  input  logic               pipe_gnt_i,
  input  logic               s2_valid_i,
  input  logic [IDX_W-1:0]   s2_idx_i,
  input  logic               s2_ok_i,
  output logic               cache_req_o,
  output logic [IDX_W-1:0]   cache_idx_o,
  output logic [LINE_W-1:0]  cache_line_o,
  input  logic               resp_valid_i,
  input  logic [IDX_W-1:0]   resp_idx_i,
  output logic               rel_o,
  output logic [IDX_W-1:0]   rel_idx_o,
  output logic [NUM_ENT-1:0] busy_o
);
  ent_state_e        st_v   [NUM_ENT];
  logic [LINE_W-1:0] line_v [NUM_ENT];
  logic [NUM_ENT-1:0] link_v, free_v, held_v, send_v, pipe_v, iss_v, busy_v;
  logic [NUM_ENT-1:0] held_hit_v, prog_hit_v, rel_v;
  logic [NUM_ENT-1:0] alloc_v, evict_v, grant_v, ok_v, fail_v, clr_v;

  logic             merge_any, free_any, send_any, rpl_empty, alloc_link;
  logic [IDX_W-1:0] merge_idx, free_idx, send_idx, rpl_head;
  st_act_e          act;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_vec
    assign free_v[i] = (st_v[i] == E_FREE);
    assign held_v[i] = (st_v[i] == E_HELD);
    assign send_v[i] = (st_v[i] == E_SEND);
    assign pipe_v[i] = (st_v[i] == E_PIPE);
    assign iss_v[i]  = (st_v[i] == E_ISSUED);
    assign busy_v[i] = !free_v[i] && !held_v[i];
    // a line whose entry releases this cycle no longer counts as in progress
    assign rel_v[i]      = resp_valid_i && (resp_idx_i == IDX_W'(i)) && iss_v[i];
    assign held_hit_v[i] = held_v[i] && (line_v[i] == st_line_i);
    assign prog_hit_v[i] = busy_v[i] && !rel_v[i] && (line_v[i] == st_line_i);
    assign alloc_v[i]    = (act == ACT_ALLOC || act == ACT_SEC) && (st_idx_o == IDX_W'(i));
    assign evict_v[i]    = evict_req_i && (evict_idx_i == IDX_W'(i));
    assign grant_v[i]    = pipe_gnt_i && pipe_req_o && (pipe_idx_o == IDX_W'(i));
    assign ok_v[i]       = s2_valid_i && s2_ok_i && (s2_idx_i == IDX_W'(i));
    assign fail_v[i]     = s2_valid_i && !s2_ok_i && (s2_idx_i == IDX_W'(i));
    assign clr_v[i]      = rel_o && (line_v[i] == line_v[resp_idx_i]);

    sbe_entry #(.LINE_W(LINE_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_v[i]),
      .alloc_line_i(st_line_i),
      .alloc_link_i(alloc_link),
      .evict_i     (evict_v[i]),
      .grant_i     (grant_v[i]),
      .s2_ok_i     (ok_v[i]),
      .s2_fail_i   (fail_v[i]),
      .resp_i      (rel_v[i]),
      .link_clr_i  (clr_v[i]),
      .state_o     (st_v[i]),
      .line_o      (line_v[i]),
      .link_o      (link_v[i])
    );
  end

  sbe_pick #(.N(NUM_ENT)) u_pick_merge (.in_i(held_hit_v), .found_o(merge_any), .idx_o(merge_idx));
  sbe_pick #(.N(NUM_ENT)) u_pick_free  (.in_i(free_v),     .found_o(free_any),  .idx_o(free_idx));
  sbe_pick #(.N(NUM_ENT)) u_pick_send  (.in_i(send_v),     .found_o(send_any),  .idx_o(send_idx));

  always_comb begin
    act      = ACT_NONE;
    st_idx_o = '0;
    if (st_valid_i) begin
      if (merge_any) begin
        act      = ACT_MERGE;
        st_idx_o = merge_idx;
      end else if (free_any) begin
        act      = (|prog_hit_v) ? ACT_SEC : ACT_ALLOC;
        st_idx_o = free_idx;
      end
    end
  end
  assign st_act_o   = act;
  assign alloc_link = (act == ACT_SEC);

  sbe_replay_fifo #(.DEPTH(NUM_ENT), .W(IDX_W)) u_rplq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (s2_valid_i && !s2_ok_i && pipe_v[s2_idx_i]),
    .push_data_i(s2_idx_i),
    .pop_i      (pipe_gnt_i && !rpl_empty),
    .head_o     (rpl_head),
    .empty_o    (rpl_empty)
  );

  // replay head outranks fresh evictions
  assign pipe_req_o  = !rpl_empty || send_any;
  assign pipe_idx_o  = !rpl_empty ? rpl_head : send_idx;
  assign pipe_line_o = line_v[pipe_idx_o];

  assign cache_req_o  = s2_valid_i && s2_ok_i && pipe_v[s2_idx_i];
  assign cache_idx_o  = s2_idx_i;
  assign cache_line_o = line_v[s2_idx_i];

  assign rel_o     = resp_valid_i && iss_v[resp_idx_i];
  assign rel_idx_o = resp_idx_i;
  assign busy_o    = busy_v;
endmodule

// File: rtl/sb_evict_ctrl_chk.sv
module sb_evict_ctrl_chk #(
  parameter int NUM_ENT = 8,
  parameter int LINE_W  = 26,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         st_act_o,
  input logic [IDX_W-1:0]   st_idx_o,
  input logic               evict_req_i,
  input logic [IDX_W-1:0]   evict_idx_i,
  input logic               pipe_req_o,
  input logic [IDX_W-1:0]   pipe_idx_o,
  input logic               cache_req_o,
  input logic [IDX_W-1:0]   cache_idx_o,
  input logic               rel_o,
  input logic [IDX_W-1:0]   rel_idx_o,
  input logic [NUM_ENT-1:0] busy_o
);
  a_r3_no_merge_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_act_o == 2'd1) |-> !busy_o[st_idx_o]);

  a_r3_sec_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_act_o == 2'd3) |=> !busy_o[$past(st_idx_o)]);

  a_r5_req_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_req_o |-> busy_o[pipe_idx_o]);

  a_r6_cache_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o |-> busy_o[cache_idx_o]);

  a_r8_rel_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |=> !busy_o[$past(rel_idx_o)]);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    a_r4_busy_from_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o[i]) |-> ($past(evict_req_i) && $past(evict_idx_i) == IDX_W'(i)));
    a_r8_idle_from_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o[i]) |-> ($past(rel_o) && $past(rel_idx_o) == IDX_W'(i)));
  end
endmodule

bind sb_evict_ctrl sb_evict_ctrl_chk #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_act_o   (st_act_o),
  .st_idx_o   (st_idx_o),
  .evict_req_i(evict_req_i),
  .evict_idx_i(evict_idx_i),
  .pipe_req_o (pipe_req_o),
  .pipe_idx_o (pipe_idx_o),
  .cache_req_o(cache_req_o),
  .cache_idx_o(cache_idx_o),
  .rel_o      (rel_o),
  .rel_idx_o  (rel_idx_o),
  .busy_o     (busy_o)
);

// File: tb/sb_evict_ctrl_bench.sv
module sb_evict_ctrl_bench;
  localparam int N  = 8;
  localparam int LW = 26;
  localparam int IW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic st_valid_i, evict_req_i, pipe_gnt_i, s2_valid_i, s2_ok_i, resp_valid_i;
  logic [LW-1:0] st_line_i;
  logic [IW-1:0] evict_idx_i, s2_idx_i, resp_idx_i;
  logic [1:0]    st_act_o;
  logic [IW-1:0] st_idx_o, pipe_idx_o, cache_idx_o, rel_idx_o;
  logic          pipe_req_o, cache_req_o, rel_o;
  logic [LW-1:0] pipe_line_o, cache_line_o;
  logic [N-1:0]  busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sb_evict_ctrl #(.NUM_ENT(N), .LINE_W(LW)) u_sb_evict_ctrl (.*);

  localparam logic [LW-1:0] LA = 26'h100, LB = 26'h200, LC = 26'h300, LD = 26'h400;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clr();
    st_valid_i = 0; st_line_i = '0; evict_req_i = 0; evict_idx_i = '0;
    pipe_gnt_i = 0; s2_valid_i = 0; s2_idx_i = '0; s2_ok_i = 0;
    resp_valid_i = 0; resp_idx_i = '0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    clr();
  endtask

  task automatic store(input logic [LW-1:0] l);
    st_valid_i = 1; st_line_i = l; #1;
  endtask

  task automatic evict(input int i);
    evict_req_i = 1; evict_idx_i = IW'(i);
  endtask

  task automatic s2(input int i, input bit ok);
    s2_valid_i = 1; s2_idx_i = IW'(i); s2_ok_i = ok; #1;
  endtask

  task automatic resp(input int i);
    resp_valid_i = 1; resp_idx_i = IW'(i); #1;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    clr();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  function automatic int exp_act(input logic [LW-1:0] l, input bit mv[N],
                                 input logic [LW-1:0] ml[N], output int idx);
    idx = 0;
    for (int i = 0; i < N; i++) if (mv[i] && ml[i] == l) begin idx = i; return 1; end
    for (int i = 0; i < N; i++) if (!mv[i]) begin idx = i; return 2; end
    return 0;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit mv[N];
    logic [LW-1:0] ml[N];
    void'($urandom(32'd20240611));
    clr();
    do_reset();

    // R1 reset state
    #1;
    chk("R1 busy", busy_o, 0);
    chk("R1 pipe_req", pipe_req_o, 0);
    chk("R1 cache_req", cache_req_o, 0);
    chk("R1 rel", rel_o, 0);
    chk("R1 act", st_act_o, 0);

    // R2 allocate and merge
    store(LA); chk("R2 alloc act", st_act_o, 2); chk("R2 alloc idx", st_idx_o, 0); tick();
    store(LA); chk("R2 merge act", st_act_o, 1); chk("R2 merge idx", st_idx_o, 0); tick();
    store(LB); chk("R2 alloc B", st_idx_o, 1); tick();
    store(LC); chk("R2 alloc C", st_idx_o, 2); tick();

    // R4 eviction accepted next cycle
    evict(0); #1; chk("R4 no req yet", pipe_req_o, 0); tick();
    #1;
    chk("R4 busy0", busy_o, 8'h01);
    chk("R4 req", pipe_req_o, 1);
    chk("R4 req line", pipe_line_o, LA);
    evict(1); tick();

    // R5 lowest index first, R3 secondary allocation
    #1;
    chk("R5 lowest idx", pipe_idx_o, 0);
    chk("R5 busy", busy_o, 8'h03);
    store(LA);
    chk("R3 sec act", st_act_o, 3);
    chk("R3 sec idx", st_idx_o, 3);
    tick();
    #1; chk("R3 sec not busy", busy_o, 8'h03);
    store(LA); chk("R3 merge into held secondary", st_act_o, 1); chk("R3 merge idx", st_idx_o, 3);
    st_valid_i = 0;
    evict(3); tick();

    // R4 linked entry ignored, R10 ungranted entry keeps request
    #1;
    chk("R4 linked evict ignored", busy_o, 8'h03);
    chk("R10 req held", pipe_req_o, 1);
    chk("R10 idx held", pipe_idx_o, 0);
    pipe_gnt_i = 1; #1;
    chk("R5 no cache at grant", cache_req_o, 0);
    tick();
    #1; chk("R5 next fresh", pipe_idx_o, 1);
    pipe_gnt_i = 1; tick();
    #1; chk("R5 none pending", pipe_req_o, 0);

    // R7 fail goes to replay; replay beats fresh
    evict(2); s2(0, 0);
    chk("R7 no cache on fail", cache_req_o, 0);
    tick();
    #1;
    chk("R7 replay req", pipe_req_o, 1);
    chk("R7 replay first", pipe_idx_o, 0);
    chk("R7 busy", busy_o, 8'h07);
    s2(1, 1);
    chk("R6 cache req", cache_req_o, 1);
    chk("R6 cache idx", cache_idx_o, 1);
    chk("R6 cache line", cache_line_o, LB);
    pipe_gnt_i = 1; tick();
    #1; chk("R7 fresh after replay", pipe_idx_o, 2);
    pipe_gnt_i = 1; tick();
    s2(0, 1); chk("R6 cache idx0", cache_idx_o, 0); chk("R6 line A", cache_line_o, LA); tick();
    s2(2, 1); resp(3);
    chk("R6 cache idx2", cache_idx_o, 2);
    chk("R8 resp to held ignored", rel_o, 0);
    tick();
    #1; chk("R6 still busy", busy_o, 8'h07);

    // R8 release, R9 link clear
    resp(0); chk("R8 rel", rel_o, 1); chk("R8 rel idx", rel_idx_o, 0); tick();
    #1; chk("R8 freed", busy_o, 8'h06);
    evict(3); tick();
    #1; chk("R9 secondary evicts", busy_o, 8'h0e);
    chk("R9 secondary req", pipe_idx_o, 3);
    resp(1); tick();
    resp(2); tick();
    #1; chk("R8 both freed", busy_o, 8'h08);

    // R7 replay order follows failure order
    store(LD); chk("R2 reuse freed", st_idx_o, 0); tick();
    evict(0); pipe_gnt_i = 1; #1; chk("R5 grant idx3", pipe_idx_o, 3); tick();
    pipe_gnt_i = 1; tick();
    s2(3, 0); tick();
    s2(0, 0); chk("R7 head idx3", pipe_idx_o, 3); tick();
    #1; chk("R7 order first", pipe_idx_o, 3); pipe_gnt_i = 1; tick();
    #1; chk("R7 order second", pipe_idx_o, 0); pipe_gnt_i = 1; tick();
    #1; chk("R7 drained", pipe_req_o, 0);

    // R2 random store decisions against a model
    do_reset();
    for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = '0; end
    for (int k = 0; k < 60; k++) begin
      int ei, ea;
      logic [LW-1:0] l;
      l = LW'($urandom_range(0, 11)) + 26'h40;
      ea = exp_act(l, mv, ml, ei);
      store(l);
      chk("R2 random act", st_act_o, ea);
      if (ea != 0) chk("R2 random idx", st_idx_o, ei);
      if (ea == 2) begin mv[ei] = 1; ml[ei] = l; end
      tick();
    end
    for (int i = 0; i < N; i++) if (!mv[i]) begin
      store(26'h3000 + LW'(i)); tick(); mv[i] = 1;
    end
    store(26'h3fff); chk("R2 full no action", st_act_o, 0); tick();

    summary();
    done = 1;
    $finish;
  end
endmodule